// File: doc/BRIEF.md
# Receive Byte Queue with Fill Trigger and Idle Timeout

This block holds the bytes a serial receiver has already turned into whole characters. It keeps them in a 16-entry circular byte queue until software reads the receive data register. It tells the surrounding status logic when to raise or drop the receive-data-full flag, and it drives the receive interrupt. The flag is requested in two cases: the fill reaches a selectable trigger level, or the line has gone quiet for 15 bit times while bytes are still waiting below that level.

The receiver offers one byte per cycle on a valid/data pair. The control register supplies a receive-enable and an interrupt-enable. The FIFO-control register supplies a 2-bit trigger selector and a one-cycle flush strobe. Each read of the receive data register produces a one-cycle pop strobe. The queue head is always visible on the read-data output, and the fill count is visible on its own output for the receive-count register.

The idle timer is a two-state machine. In state TM_IDLE it does nothing. In state TM_RUN it counts toward a limit of 15 times the bit time. It moves from TM_IDLE or TM_RUN to TM_RUN with a zeroed count on a restart, which is a push that leaves the fill below the trigger. It moves from TM_RUN to TM_IDLE in three cases: on a cancel (a push that reaches the trigger while interrupts are enabled), on expiry (the count reaches the limit), or on a flush.

Top module: `rxq_trig_top`

## Requirements
- R1: The queue holds up to 16 bytes and returns them in arrival order. `fill_count` gives the number held and `rd_data` shows the oldest byte. Both update on the clock edge after a push or pop.
- R2: `trig_sel` sets the trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14.
- R3: A `fifo_flush` cycle leaves the queue empty on the next edge. It overrides any push or pop in that same cycle.
- R4: A byte is stored only while `rx_enable` is high and the queue holds fewer than 16 bytes. A byte offered to a full queue is dropped, even in a cycle that also pops.
- R5: A stored byte that brings the fill to the trigger level or above pulses `rdf_set_req` for one cycle after that edge. If `irq_enable` is high, the same edge raises `rx_irq` and cancels the idle timer.
- R6: A stored byte that leaves the fill below the trigger restarts the idle timer for 15×BIT_CYCLES clock cycles. On expiry, `rdf_set_req` pulses and `rx_irq` rises if `irq_enable` is high. If expiry coincides with a pop, the clear request is suppressed.
- R7: A stored byte that reaches the trigger while `irq_enable` is low leaves a running idle timer untouched, so the timer still expires later.
- R8: A pop of a non-empty queue removes the oldest byte. If the fill is then below the trigger, `rdf_clr_req` pulses for one cycle.
- R9: A pop of an empty queue changes nothing and raises no request. `rd_data` reads 0 whenever the queue is empty.
- R10: `rx_irq` stays high once raised until `irq_enable` is low at a clock edge, and it is low after that edge.
- R11: A byte stored in the exact cycle the idle timer would expire takes precedence. That expiry produces no set request, and the timer follows the new byte.
- R12: A push and a pop in the same cycle leave the fill unchanged. The request raised is judged on that fill: a set request at or above the trigger, a clear request below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_byte | input | DATA_W | The received byte |
| rx_enable | input | 1 | Receive enable from the control register |
| irq_enable | input | 1 | Receive interrupt enable from the control register |
| trig_sel | input | 2 | Trigger level selector (0:1, 1:4, 2:8, 3:14) |
| fifo_flush | input | 1 | One-cycle strobe that empties the queue |
| rd_pop | input | 1 | One-cycle strobe from a read of the receive data register |
| rd_data | output | DATA_W | Oldest byte held, 0 when empty |
| fill_count | output | CNT_W | Number of bytes held |
| rdf_set_req | output | 1 | One-cycle request to set the receive-data-full flag |
| rdf_clr_req | output | 1 | One-cycle request to clear the receive-data-full flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Two groups of events can land in the same cycle.

The first group is expiry of the idle timer together with queue traffic. The bench counts exactly 15×BIT_CYCLES edges from a restarting push. It then places either a new byte or a pop in the expiry cycle itself. With a new byte, the bench expects no set request and a fresh expiry one full window later. With a pop, it expects a set request and no clear request.

The second group is a push and a pop in one cycle. The bench runs this at, below and at the full-queue boundary. It judges the result through the fill count, the head byte order and which of the two flag requests pulses.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [0:0] {
        TM_IDLE = 1'b0,
        TM_RUN  = 1'b1
    } tm_state_e;

    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        int unsigned lvl;
        case (sel)
            2'd0:    lvl = 1;
            2'd1:    lvl = 4;
            2'd2:    lvl = 8;
            default: lvl = depth - 2;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PTR_W  = $clog2(DEPTH),
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  count_next
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [PTR_W-1:0]  wr_ptr_d, rd_ptr_d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        if (flush) begin
            wr_ptr_d   = '0;
            rd_ptr_d   = '0;
            count_next = '0;
        end else begin
            wr_ptr_d   = push ? bump(wr_ptr_q) : wr_ptr_q;
            rd_ptr_d   = pop  ? bump(rd_ptr_q) : rd_ptr_q;
            count_next = count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count    <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_d;
            rd_ptr_q <= rd_ptr_d;
            count    <= count_next;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr_q] <= wdata;
        end
    end

    assign head = (count == '0) ? '0 : mem[rd_ptr_q];

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
    import rxq_pkg::*;
#(
    parameter int unsigned BIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cancel,
    input  logic flush,
    output logic expire
);

    localparam int unsigned TIMEOUT = 15 * BIT_CYCLES;
    localparam int unsigned TMR_W   = $clog2(TIMEOUT);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(TIMEOUT - 1);

    tm_state_e        state_q, state_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        if (flush) begin
            state_d = TM_IDLE;
            tmr_d   = '0;
        end else if (restart) begin
            state_d = TM_RUN;
            tmr_d   = '0;
        end else if (cancel) begin
            state_d = TM_IDLE;
            tmr_d   = '0;
        end else begin
            unique case (state_q)
                TM_IDLE: begin
                    tmr_d = '0;
                end
                TM_RUN: begin
                    if (tmr_q == LAST) begin
                        state_d = TM_IDLE;
                        tmr_d   = '0;
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end
                default: begin
                    state_d = TM_IDLE;
                    tmr_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb begin
        expire = 1'b0;
        unique case (state_q)
            TM_IDLE: expire = 1'b0;
            TM_RUN:  expire = (tmr_q == LAST) && !flush && !restart && !cancel;
            default: expire = 1'b0;
        endcase
    end

endmodule

// File: rtl/rxq_flagger.sv
module rxq_flagger
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [CNT_W-1:0] count_next,
    input  logic [1:0]       trig_sel,
    input  logic             irq_en,
    input  logic             expire,
    output logic             restart,
    output logic             cancel,
    output logic             set_q,
    output logic             clr_q,
    output logic             irq_q
);

    logic [CNT_W-1:0] level;
    logic             at_level;
    logic             trig_ev;

    always_comb begin
        level    = CNT_W'(trig_level(trig_sel, DEPTH));
        at_level = (count_next >= level);
        trig_ev  = push && at_level;
        restart  = push && !at_level;
        cancel   = trig_ev && irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q <= 1'b0;
            clr_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            set_q <= trig_ev || expire;
            clr_q <= pop && !at_level && !expire;
            irq_q <= irq_en && (irq_q || trig_ev || expire);
        end
    end

endmodule

// File: rtl/rxq_trig_top.sv
module rxq_trig_top #(
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned BIT_CYCLES = 16,
    parameter int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_enable,
    input  logic              irq_enable,
    input  logic [1:0]        trig_sel,
    input  logic              fifo_flush,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fill_count,
    output logic              rdf_set_req,
    output logic              rdf_clr_req,
    output logic              rx_irq
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic             push_ok;
    logic             pop_ok;
    logic [CNT_W-1:0] count_next;
    logic             restart;
    logic             cancel;
    logic             expire;

    assign push_ok = rx_valid && rx_enable && !fifo_flush && (fill_count != FULL);
    assign pop_ok  = rd_pop && !fifo_flush && (fill_count != '0);

    rxq_store #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_ok),
        .pop       (pop_ok),
        .flush     (fifo_flush),
        .wdata     (rx_byte),
        .head      (rd_data),
        .count     (fill_count),
        .count_next(count_next)
    );

    rxq_idle_timer #(
        .BIT_CYCLES(BIT_CYCLES)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .cancel (cancel),
        .flush  (fifo_flush),
        .expire (expire)
    );

    rxq_flagger #(
        .DEPTH(DEPTH),
        .CNT_W(CNT_W)
    ) flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_ok),
        .pop       (pop_ok),
        .count_next(count_next),
        .trig_sel  (trig_sel),
        .irq_en    (irq_enable),
        .expire    (expire),
        .restart   (restart),
        .cancel    (cancel),
        .set_q     (rdf_set_req),
        .clr_q     (rdf_clr_req),
        .irq_q     (rx_irq)
    );

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_enable,
    input logic              irq_enable,
    input logic              fifo_flush,
    input logic              rd_pop,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  fill_count,
    input logic              rdf_set_req,
    input logic              rdf_clr_req,
    input logic              rx_irq
);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH)); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_flush |=> (fill_count == $past(fill_count)) ||
                        (fill_count == $past(fill_count) + 1'b1) ||
                        (fill_count + 1'b1 == $past(fill_count))); // R1

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> (fill_count == '0)); // R3

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !rd_pop && !fifo_flush) |=> $stable(fill_count)); // R4

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == CNT_W'(DEPTH) && !rd_pop && !fifo_flush) |=> (fill_count == CNT_W'(DEPTH))); // R4

    AST_CLR_FROM_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdf_clr_req) |-> $past(rd_pop)); // R8

    AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0 && rd_pop && !rx_valid) |=> (fill_count == '0 && !rdf_clr_req)); // R9

    AST_EMPTY_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> (rd_data == '0)); // R9

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_enable |=> !rx_irq); // R10

    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdf_set_req && rdf_clr_req)); // R12

endmodule

bind rxq_trig_top rxq_checker #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_enable  (rx_enable),
    .irq_enable (irq_enable),
    .fifo_flush (fifo_flush),
    .rd_pop     (rd_pop),
    .rd_data    (rd_data),
    .fill_count (fill_count),
    .rdf_set_req(rdf_set_req),
    .rdf_clr_req(rdf_clr_req),
    .rx_irq     (rx_irq)
);

// File: tb/rxq_trig_top_tb_top.sv
module rxq_trig_top_tb_top;

    localparam int DEPTH = 16;
    localparam int BITC  = 2;
    localparam int TO    = 15 * BITC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_enable = 1'b0;
    logic       irq_enable = 1'b0;
    logic [1:0] trig_sel = '0;
    logic       fifo_flush = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] fill_count;
    logic       rdf_set_req;
    logic       rdf_clr_req;
    logic       rx_irq;

    int errors = 0;
    int checks = 0;
    byte unsigned mq[$];
    int  tleft = 0;
    bit  irq_m = 1'b0;

    always #2 clk = ~clk;

    rxq_trig_top #(
        .DEPTH(DEPTH), .DATA_W(8), .BIT_CYCLES(BITC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_enable(rx_enable), .irq_enable(irq_enable), .trig_sel(trig_sel),
        .fifo_flush(fifo_flush), .rd_pop(rd_pop), .rd_data(rd_data),
        .fill_count(fill_count), .rdf_set_req(rdf_set_req),
        .rdf_clr_req(rdf_clr_req), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lvl_of(input logic [1:0] s);
        case (s)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    task automatic cyc(input bit v, input logic [7:0] d, input bit p, input bit f);
        int lvl, n0, nc, hd;
        bit push_ok, pop_ok, expire, set_e, clr_e;
        lvl     = lvl_of(trig_sel);
        n0      = mq.size();
        push_ok = v && rx_enable && !f && (n0 != DEPTH);
        pop_ok  = p && !f && (n0 != 0);
        rx_valid = v; rx_byte = d; rd_pop = p; fifo_flush = f;
        @(posedge clk);
        #1;
        rx_valid = 1'b0; rd_pop = 1'b0; fifo_flush = 1'b0;
        if (f) mq.delete();
        else begin
            if (pop_ok) void'(mq.pop_front());
            if (push_ok) mq.push_back(d);
        end
        nc = mq.size();
        expire = 1'b0;
        if (f) tleft = 0;
        else if (push_ok && nc < lvl) tleft = TO;
        else if (push_ok && irq_enable) tleft = 0;
        else if (tleft == 1) begin expire = 1'b1; tleft = 0; end
        else if (tleft > 0) tleft--;
        set_e = (push_ok && nc >= lvl) || expire;
        clr_e = pop_ok && nc < lvl && !expire;
        irq_m = irq_enable ? (irq_m | set_e) : 1'b0;
        hd = (nc != 0) ? int'(mq[0]) : 0;
        chk("R1 count", int'(fill_count), nc);
        chk("R1 head", int'(rd_data), hd);
        chk("R5 set request", int'(rdf_set_req), int'(set_e));
        chk("R8 clear request", int'(rdf_clr_req), int'(clr_e));
        chk("R10 interrupt", int'(rx_irq), int'(irq_m));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 reset count", int'(fill_count), 0);
        chk("R9 reset head", int'(rd_data), 0);
        chk("R5 reset set", int'(rdf_set_req), 0);
        chk("R8 reset clear", int'(rdf_clr_req), 0);
        chk("R10 reset irq", int'(rx_irq), 0);

        // Sweep every trigger level: fill past full, then drain
        rx_enable = 1'b1;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            irq_enable = 1'b1;
            for (int i = 0; i <= DEPTH; i++) begin
                cyc(1'b1, 8'(s * 32 + i + 1), 1'b0, 1'b0);
                chk("R2 level", int'(rdf_set_req), int'((i < DEPTH) && (i + 1 >= lvl_of(2'(s)))));
                chk("R4 full bound", int'(fill_count), (i + 1 > DEPTH) ? DEPTH : i + 1);
            end
            for (int i = 0; i < DEPTH; i++) begin
                cyc(1'b0, 8'h00, 1'b1, 1'b0);
                chk("R8 drain clear", int'(rdf_clr_req), int'(DEPTH - 1 - i < lvl_of(2'(s))));
            end
            irq_enable = 1'b0;
            cyc(1'b0, 8'h00, 1'b0, 1'b0);
            chk("R10 irq dropped", int'(rx_irq), 0);
        end

        // R4: receive disabled
        rx_enable = 1'b0;
        cyc(1'b1, 8'h5A, 1'b0, 1'b0);
        chk("R4 disabled", int'(fill_count), 0);
        rx_enable = 1'b1;

        // R9: pop of empty queue
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R9 empty pop count", int'(fill_count), 0);
        chk("R9 empty pop clear", int'(rdf_clr_req), 0);

        // R3: flush wins over push and pop
        trig_sel = 2'd3;
        for (int i = 0; i < 5; i++) cyc(1'b1, 8'(8'h40 + i), 1'b0, 1'b0);
        cyc(1'b1, 8'hAA, 1'b1, 1'b1);
        chk("R3 flush", int'(fill_count), 0);
        chk("R3 flush head", int'(rd_data), 0);

        // R6: timeout below trigger
        trig_sel = 2'd1;
        irq_enable = 1'b1;
        cyc(1'b1, 8'h11, 1'b0, 1'b0);
        idle(TO - 1);
        chk("R6 before expiry", int'(rdf_set_req), 0);
        idle(1);
        chk("R6 expiry set", int'(rdf_set_req), 1);
        chk("R6 expiry irq", int'(rx_irq), 1);

        // R10: disable drops interrupt
        irq_enable = 1'b0;
        idle(1);
        chk("R10 disable", int'(rx_irq), 0);

        // R11: push in the expiry cycle
        cyc(1'b1, 8'h12, 1'b0, 1'b0);
        idle(TO - 1);
        cyc(1'b1, 8'h13, 1'b0, 1'b0);
        chk("R11 expiry displaced", int'(rdf_set_req), 0);
        idle(TO - 1);
        chk("R11 not yet", int'(rdf_set_req), 0);
        idle(1);
        chk("R11 later expiry", int'(rdf_set_req), 1);

        // R6: pop in the expiry cycle
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        cyc(1'b1, 8'h21, 1'b0, 1'b0);
        cyc(1'b1, 8'h22, 1'b0, 1'b0);
        idle(TO - 1);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 pop at expiry set", int'(rdf_set_req), 1);
        chk("R6 pop at expiry clear", int'(rdf_clr_req), 0);

        // R7: trigger push with interrupts off keeps timer
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        trig_sel = 2'd1;
        cyc(1'b1, 8'h31, 1'b0, 1'b0);
        idle(5);
        trig_sel = 2'd0;
        cyc(1'b1, 8'h32, 1'b0, 1'b0);
        chk("R7 trigger set", int'(rdf_set_req), 1);
        idle(TO - 7);
        chk("R7 not yet", int'(rdf_set_req), 0);
        idle(1);
        chk("R7 expiry kept", int'(rdf_set_req), 1);

        // R5: trigger push with interrupts on cancels timer
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        trig_sel = 2'd1;
        irq_enable = 1'b1;
        cyc(1'b1, 8'h41, 1'b0, 1'b0);
        idle(5);
        trig_sel = 2'd0;
        cyc(1'b1, 8'h42, 1'b0, 1'b0);
        chk("R5 irq raised", int'(rx_irq), 1);
        idle(TO - 6);
        chk("R5 timer cancelled", int'(rdf_set_req), 0);
        idle(3);

        // R12: simultaneous push and pop
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        trig_sel = 2'd1;
        for (int i = 0; i < 4; i++) cyc(1'b1, 8'(8'h50 + i), 1'b0, 1'b0);
        cyc(1'b1, 8'h54, 1'b1, 1'b0);
        chk("R12 count kept", int'(fill_count), 4);
        chk("R12 set at level", int'(rdf_set_req), 1);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        cyc(1'b1, 8'h55, 1'b1, 1'b0);
        chk("R12 clear below", int'(rdf_clr_req), 1);
        chk("R12 no set below", int'(rdf_set_req), 0);
        for (int i = 0; i < 13; i++) cyc(1'b1, 8'(8'h60 + i), 1'b0, 1'b0);
        cyc(1'b1, 8'hEE, 1'b1, 1'b0);
        chk("R12 full drop count", int'(fill_count), 15);
        chk("R4 full drop set", int'(rdf_set_req), 0);
        for (int i = 0; i < 15; i++) cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R1 drained", int'(fill_count), 0);
        idle(TO + 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule